// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block watches a running clock's hour, minute and second bytes and raises an alarm flag when they agree with three programmed alarm bytes. The comparison is made only when the time-keeping logic pulses its update strobe, which it does in the cycle in which the freshly advanced time is on the time inputs. The alarm therefore fires for the new second.

Any alarm byte can be taken out of the comparison by setting both of its top two bits. This is how the repeat rate is chosen. With no byte excluded the alarm repeats daily. With the hour excluded it repeats hourly. With the hour and minute excluded it repeats each minute. With all three excluded it fires on every update.

The flag is set on a match whether or not the alarm interrupt is enabled. It stays set until a clear strobe arrives, which is pulsed when the status register is read. The interrupt-request contribution is the flag gated by the enable.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, `alm_flag` and `alm_irq` are 0.
- R2: When no alarm byte is a wildcard, a strobed update sets `alm_flag` only if the hour, minute and second inputs all equal their alarm bytes.
- R3: An alarm byte is a wildcard when bits [7:6] are both 1, whatever its bits [5:0] hold. A byte with only bit 7 set (for example 8'h80) is compared normally.
- R4: With only the hour byte a wildcard, a strobed update sets the flag whenever the minute and second both match, for any hour.
- R5: With the hour and minute bytes wildcards, a strobed update sets the flag whenever the second matches.
- R6: With all three bytes wildcards, every strobed update sets the flag.
- R7: Time inputs that match in a cycle without `upd_stb` leave the flag unchanged.
- R8: The flag is set one cycle after the strobed matching update, even when `alm_ie` is 0. It then stays set until `flag_clr` is pulsed, and it is 0 in the cycle after that pulse.
- R9: `alm_irq` equals `alm_flag` while `alm_ie` is 1 and is 0 while `alm_ie` is 0.
- R10: When `flag_clr` and a strobed match occur in the same cycle, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_stb | input | 1 | One-cycle pulse: the time inputs now hold the updated time |
| cur_hr | input | 8 | Current hours byte |
| cur_min | input | 8 | Current minutes byte |
| cur_sec | input | 8 | Current seconds byte |
| alm_hr | input | 8 | Hours alarm byte (wildcard when [7:6]=11) |
| alm_min | input | 8 | Minutes alarm byte (wildcard when [7:6]=11) |
| alm_sec | input | 8 | Seconds alarm byte (wildcard when [7:6]=11) |
| alm_ie | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the flag (status read) |
| alm_flag | output | 1 | Alarm event flag |
| alm_irq | output | 1 | Interrupt-request contribution |

## Verification
All eight wildcard masks are swept against a grid of times: each of hour, minute and second is set either equal or unequal to its alarm byte. This distinguishes a field that is wrongly excluded from one that is wrongly compared, and checks each repeat rate. The wildcard bytes are written with differing low bits, and one test uses an 8'h80 byte, so that the exact two-bit wildcard encoding is pinned down. The clear strobe is given on alternating steps, and the enable is toggled per mask. Together these exercise holding, clearing, a clear that collides with a set, and interrupt gating. Matching time applied without a strobe confirms that the compare happens only on updates.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int BYTE_W = 8;
  localparam int NFIELD = 3;

  // both top bits set marks a byte as excluded from the compare
  function automatic logic is_wild(input logic [BYTE_W-1:0] a);
    return &a[BYTE_W-1:BYTE_W-2];
  endfunction

  function automatic logic field_ok(input logic [BYTE_W-1:0] a,
                                    input logic [BYTE_W-1:0] t);
    return is_wild(a) || (a == t);
  endfunction
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match
  import alarm_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter int N = NFIELD
) (
  input  logic [N*W-1:0] alm_vec,
  input  logic [N*W-1:0] cur_vec,
  output logic [N-1:0]   wild_vec,
  output logic [N-1:0]   ok_vec,
  output logic           all_ok
);
  for (genvar i = 0; i < N; i++) begin : g_fld
    assign wild_vec[i] = is_wild(alm_vec[i*W +: W]);
    assign ok_vec[i]   = field_ok(alm_vec[i*W +: W], cur_vec[i*W +: W]);
    // R3
    always_comb wild_ok_chk: assert (!wild_vec[i] || ok_vec[i]);
  end
  assign all_ok = &ok_vec;
endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;   // set wins over clear
    else if (clr_evt) flag <= 1'b0;
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_evt |=> flag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt && !set_evt |=> !flag);
  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !set_evt |=> !flag);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_stb,
  input  logic [BYTE_W-1:0] cur_hr,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] alm_hr,
  input  logic [BYTE_W-1:0] alm_min,
  input  logic [BYTE_W-1:0] alm_sec,
  input  logic              alm_ie,
  input  logic              flag_clr,
  output logic              alm_flag,
  output logic              alm_irq
);
  localparam int VW = NFIELD * BYTE_W;

  logic [VW-1:0]     alm_vec, cur_vec;
  logic [NFIELD-1:0] wild_vec, ok_vec;
  logic              all_ok;
  logic              hit_evt;

  // field order: 0 = seconds, 1 = minutes, 2 = hours
  assign alm_vec = {alm_hr, alm_min, alm_sec};
  assign cur_vec = {cur_hr, cur_min, cur_sec};

  alarm_field_match #(.W(BYTE_W), .N(NFIELD)) u_match (
    .alm_vec (alm_vec),
    .cur_vec (cur_vec),
    .wild_vec(wild_vec),
    .ok_vec  (ok_vec),
    .all_ok  (all_ok)
  );

  assign hit_evt = upd_stb && all_ok;

  alarm_flag_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(hit_evt),
    .clr_evt(flag_clr),
    .flag   (alm_flag)
  );

  assign alm_irq = alm_flag && alm_ie;

  // R6
  all_wild_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb && (&wild_vec) |=> alm_flag);
  // R10
  clr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt && flag_clr |=> alm_flag);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_irq |-> alm_ie && alm_flag);
  // R7
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> $past(upd_stb));
endmodule

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_stb = 0, alm_ie = 0, flag_clr = 0;
  logic [7:0] cur_hr = 0, cur_min = 0, cur_sec = 0;
  logic [7:0] alm_hr = 0, alm_min = 0, alm_sec = 0;
  logic alm_flag, alm_irq;
  int n_vec = 0, n_bad = 0;
  bit exp_flag = 0;

  always #5 clk = ~clk;

  alarm_match_unit u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one step: drive at negedge, result visible at the following negedge
  task automatic step(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                      input bit stb, input bit clr, input string req);
    int agree;
    cur_hr = h; cur_min = m; cur_sec = s; upd_stb = stb; flag_clr = clr;
    agree = 0;
    if (alm_hr[7:6] == 2'b11 || alm_hr == h) agree += 1;
    if (alm_min[7:6] == 2'b11 || alm_min == m) agree += 1;
    if (alm_sec[7:6] == 2'b11 || alm_sec == s) agree += 1;
    if (stb && agree == 3) exp_flag = 1;
    else if (clr) exp_flag = 0;
    @(negedge clk);
    upd_stb = 0; flag_clr = 0;
    chk(req, alm_flag, exp_flag);
    chk("R9", alm_irq, exp_flag && alm_ie);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1", alm_flag, 1'b0);
    chk("R1", alm_irq, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // sweep all wildcard masks (bit2 hr, bit1 min, bit0 sec)
    for (int mask = 0; mask < 8; mask++) begin
      string rq;
      alm_ie  = mask[0];
      alm_hr  = mask[2] ? 8'hC0 + 8'(mask) : 8'd5;
      alm_min = mask[1] ? 8'hFF : 8'd17;
      alm_sec = mask[0] ? 8'hC3 : 8'd42;
      rq = (mask == 0) ? "R2" : (mask == 4) ? "R4" : (mask == 6) ? "R5" :
           (mask == 7) ? "R6" : "R3";
      step(0, 0, 0, 0, 1, "R8");
      for (int k = 0; k < 8; k++) begin
        logic [7:0] h, m, s;
        h = k[2] ? 8'd5 : 8'd4;
        m = k[1] ? 8'd17 : 8'd16;
        s = k[0] ? 8'd42 : 8'd41;
        // R7: matching time without strobe
        step(h, m, s, 0, 0, "R7");
        step(h, m, s, 1, 0, rq);
        step(h, m, s, 0, 0, "R8");          // hold, no clear
        step(h, m, s, 1, k[0], "R10");      // set vs clear collision
        step(h, m, s, 0, 1, "R8");          // clear
      end
    end

    // R3: 8'h80 is not a wildcard
    alm_hr = 8'hC0; alm_min = 8'hC0; alm_sec = 8'h80; alm_ie = 1;
    step(0, 0, 8'd1, 1, 1, "R3");
    step(0, 0, 8'h80, 1, 0, "R3");
    // R8: set with interrupt disabled
    alm_ie = 0;
    step(0, 0, 0, 0, 1, "R8");
    step(0, 0, 8'h80, 1, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    alm_ie = 1;
    @(negedge clk);
    chk("R9", alm_irq, 1'b1);
    // R6: every update with all wildcards
    alm_hr = 8'hFF; alm_min = 8'hC7; alm_sec = 8'hE5;
    for (int s = 0; s < 60; s++) begin
      step(8'd23, 8'd59, 8'(s), 0, 1, "R8");
      step(8'd23, 8'd59, 8'(s), 1, 0, "R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule